// File: doc/BRIEF.md
# LCD Scanline Mode Sequencer

This block paces a tile-based handheld-style LCD through its per-line phases. Each machine-cycle tick moves a dot counter forward, and the counter selects one of four modes in turn: sprite search, pixel transfer, horizontal blank, and, once the visible lines are done, vertical blank. The block also keeps the current line number and compares it with a programmable compare value.

A small CPU-facing write port loads either the status register or the line-compare register. In the status register, the upper five bits are software settings. The lowest three bits always show the line-match flag and the current mode, whatever software writes to them. Two interrupt request pulses come out of the block. One fires when the frame enters vertical blank. The other fires when the OR of four individually enabled status sources first becomes true.

Clearing the LCD enable input parks the sequencer. It stays in vertical blank at line 0 with the dot count cleared until the LCD is enabled again.

Top module: `lcd_timing_seq`

## Requirements
- R1: Each cycle with `tick` high and `lcd_en` high adds DOTS_PER_TICK dots to the line position. The mode is 2 (sprite search) for the first OAM_DOTS dots of a visible line, 3 (transfer) for the next XFER_DOTS dots, and 0 (horizontal blank) for the rest of the LINE_DOTS line. Without a tick, neither mode nor line changes.
- R2: In the cycle after `lcd_en` is seen low, the mode is 1 (vertical blank), the line number is 0 and the dot position is 0. This holds whether or not ticks arrive.
- R3: When a visible line ends, the line number increments. If the new value equals VBLANK_START the mode becomes 1; otherwise it becomes 2.
- R4: A vertical-blank line also lasts LINE_DOTS dots. After the line numbered VBLANK_START+VBLANK_LINES-1, the line number wraps to 0 and the mode becomes 2. A vertical-blank line numbered below VBLANK_START (the first line after enabling) likewise ends at line 0 in mode 2.
- R5: `irq_vblank` pulses once each time a horizontal blank hands over to vertical blank. It does not pulse when the LCD is disabled or enabled.
- R6: A write with `wr_sel`=0 stores `wr_data[7:3]` in status bits 7..3. Status read data is {stored bits 7..3, match flag in bit 2, mode in bits 1..0}. Mode codes are 0 horizontal blank, 1 vertical blank, 2 sprite search, 3 transfer.
- R7: A write with `wr_sel`=1 loads the 8-bit compare value. On every tick, bit 2 of the status register takes the value (line number after that tick == compare value). Bit 2 changes only on a tick, so a compare write shows up at the next tick.
- R8: The status interrupt condition is the OR of four terms: bit 6 and the match flag, bit 5 and mode 2, bit 4 and mode 1, bit 3 and mode 0. `irq_stat` pulses on each rising edge of that combined condition only.
- R9: Each interrupt pulse lasts one cycle and appears one cycle after its condition first holds.
- R10: After reset the mode is 1, the line number is 0, the status read data is 0x01, the compare value is 0, and neither interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lcd_en | input | 1 | LCD enable; low parks the sequencer |
| tick | input | 1 | One machine cycle elapsed |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 line compare |
| wr_data | input | 8 | Write data |
| mode | output | 2 | Current mode code |
| ly | output | LY_W | Current line number |
| stat_rdata | output | 8 | Status register read value |
| irq_vblank | output | 1 | Vertical-blank request pulse |
| irq_stat | output | 1 | Status interrupt request pulse |

## Verification
The bench shrinks the timing to 8 sprite-search dots, 12 transfer dots and 28-dot lines. It places vertical blank at line 3 and makes it 2 lines long, so a frame takes 35 ticks. With these values every mode boundary, the vertical-blank entry, the line wrap and the first-line-after-enable path come up within a few hundred cycles. The bench can then run whole frames per interrupt source and count the pulses, including the case where two enabled sources overlap and only one edge results.

// File: rtl/lcd_seq_pkg.sv
// Shared types for the LCD scanline sequencer.
// Assumes the mode code values are seen by software in status bits 1..0.
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_OAM    = 2'd2,
        MODE_XFER   = 2'd3
    } lcd_mode_e;

    localparam logic SEL_STAT = 1'b0;
    localparam logic SEL_LYC  = 1'b1;

endpackage

// File: rtl/lcd_scan_ctr.sv
// Dot/line/mode counter. Advances by DOTS_PER_TICK per tick while enabled,
// walks the modes of a line, and steps through visible and blank lines.
// Assumes every mode length is a multiple of DOTS_PER_TICK and that
// OAM_DOTS + XFER_DOTS < LINE_DOTS. Also exports the next-state line number.
module lcd_scan_ctr
    import lcd_seq_pkg::*;
#(
    parameter int DOTS_PER_TICK = 4,
    parameter int OAM_DOTS      = 80,
    parameter int XFER_DOTS     = 172,
    parameter int LINE_DOTS     = 456,
    parameter int VBLANK_START  = 143,
    parameter int VBLANK_LINES  = 10,
    parameter int LY_W          = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            tick,
    output lcd_mode_e       mode_o,
    output logic [LY_W-1:0] ly_o,
    output logic [LY_W-1:0] ly_nxt_o
);

    localparam int DOT_W = $clog2(LINE_DOTS + DOTS_PER_TICK);
    localparam logic [DOT_W-1:0] STEP      = DOT_W'(DOTS_PER_TICK);
    localparam logic [DOT_W-1:0] OAM_END   = DOT_W'(OAM_DOTS);
    localparam logic [DOT_W-1:0] XFER_END  = DOT_W'(OAM_DOTS + XFER_DOTS);
    localparam logic [DOT_W-1:0] LINE_END  = DOT_W'(LINE_DOTS);
    localparam logic [LY_W-1:0]  VBL_FIRST = LY_W'(VBLANK_START);
    localparam logic [LY_W-1:0]  VBL_LAST  = LY_W'(VBLANK_START + VBLANK_LINES - 1);

    logic [DOT_W-1:0] dot_q, dot_nxt, dot_sum;
    logic [LY_W-1:0]  ly_q, ly_nxt, ly_inc;
    lcd_mode_e        mode_q, mode_nxt;

    // Next-state logic for dot position, line number and mode.
    always_comb begin
        dot_sum  = dot_q + STEP;
        ly_inc   = ly_q + 1'b1;
        dot_nxt  = dot_q;
        ly_nxt   = ly_q;
        mode_nxt = mode_q;
        if (!en) begin
            dot_nxt  = '0;
            ly_nxt   = '0;
            mode_nxt = MODE_VBLANK;
        end else if (tick) begin
            if (dot_sum >= LINE_END) begin
                dot_nxt = '0;
                if (mode_q == MODE_VBLANK) begin
                    if (ly_q == VBL_LAST || ly_q < VBL_FIRST) begin
                        ly_nxt   = '0;
                        mode_nxt = MODE_OAM;
                    end else begin
                        ly_nxt = ly_inc;
                    end
                end else begin
                    ly_nxt   = ly_inc;
                    mode_nxt = (ly_inc == VBL_FIRST) ? MODE_VBLANK : MODE_OAM;
                end
            end else begin
                dot_nxt = dot_sum;
                if (mode_q == MODE_OAM && dot_sum >= OAM_END) begin
                    mode_nxt = MODE_XFER;
                end else if (mode_q == MODE_XFER && dot_sum >= XFER_END) begin
                    mode_nxt = MODE_HBLANK;
                end
            end
        end
    end

    // State registers; reset parks in vertical blank at line 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_q  <= '0;
            ly_q   <= '0;
            mode_q <= MODE_VBLANK;
        end else begin
            dot_q  <= dot_nxt;
            ly_q   <= ly_nxt;
            mode_q <= mode_nxt;
        end
    end

    assign mode_o   = mode_q;
    assign ly_o     = ly_q;
    assign ly_nxt_o = ly_nxt;

endmodule

// File: rtl/lcd_stat_reg.sv
// Status and line-compare registers. Software owns status bits 7..3; bit 2
// is the line-match flag, refreshed on every tick from the next-state line;
// bits 1..0 mirror the mode. Assumes ly_nxt equals the line after this cycle.
module lcd_stat_reg
    import lcd_seq_pkg::*;
#(
    parameter int LY_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [7:0]      wr_data,
    input  logic [LY_W-1:0] ly_nxt,
    input  lcd_mode_e       mode,
    output logic [7:0]      rdata,
    output logic [3:0]      src_en,
    output logic            match
);

    logic [4:0]      ctrl_q;
    logic [LY_W-1:0] lyc_q;
    logic            match_q;

    // Software writes to the control bits and the compare value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            lyc_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_STAT) ctrl_q <= wr_data[7:3];
            else                    lyc_q  <= LY_W'(wr_data);
        end
    end

    // Line-match flag, refreshed once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    match_q <= 1'b0;
        else if (tick) match_q <= (ly_nxt == lyc_q);
    end

    assign rdata  = {ctrl_q, match_q, mode};
    assign src_en = ctrl_q[3:0];
    assign match  = match_q;

endmodule

// File: rtl/lcd_irq_edge.sv
// Rising-edge pulse generator for N request conditions; each pulse is one
// registered cycle long. Assumes conditions are free of glitches at the edge.
module lcd_irq_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    output logic [N-1:0] pulse
);

    logic [N-1:0] prev_q;

    // Remember last condition and emit a pulse on each 0->1 change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            pulse  <= '0;
        end else begin
            prev_q <= cond;
            pulse  <= cond & ~prev_q;
        end
    end

endmodule

// File: rtl/lcd_timing_seq.sv
// Top of the LCD scanline sequencer: counter, status registers and the two
// interrupt request pulses. Assumes one tick equals one machine cycle.
module lcd_timing_seq
    import lcd_seq_pkg::*;
#(
    parameter int DOTS_PER_TICK = 4,
    parameter int OAM_DOTS      = 80,
    parameter int XFER_DOTS     = 172,
    parameter int LINE_DOTS     = 456,
    parameter int VBLANK_START  = 143,
    parameter int VBLANK_LINES  = 10,
    parameter int LY_W          = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lcd_en,
    input  logic            tick,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [7:0]      wr_data,
    output logic [1:0]      mode,
    output logic [LY_W-1:0] ly,
    output logic [7:0]      stat_rdata,
    output logic            irq_vblank,
    output logic            irq_stat
);

    localparam logic [LY_W-1:0] VBL_FIRST = LY_W'(VBLANK_START);

    lcd_mode_e       mode_w;
    logic [LY_W-1:0] ly_w, ly_nxt_w;
    logic [3:0]      src_en;
    logic            match_w;
    logic [1:0]      irq_cond, irq_pulse;

    lcd_scan_ctr #(
        .DOTS_PER_TICK(DOTS_PER_TICK), .OAM_DOTS(OAM_DOTS), .XFER_DOTS(XFER_DOTS),
        .LINE_DOTS(LINE_DOTS), .VBLANK_START(VBLANK_START),
        .VBLANK_LINES(VBLANK_LINES), .LY_W(LY_W)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .en(lcd_en), .tick(tick),
        .mode_o(mode_w), .ly_o(ly_w), .ly_nxt_o(ly_nxt_w)
    );

    lcd_stat_reg #(.LY_W(LY_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ly_nxt(ly_nxt_w), .mode(mode_w),
        .rdata(stat_rdata), .src_en(src_en), .match(match_w)
    );

    // Request conditions: [0] in a real vertical blank, [1] status sources.
    always_comb begin
        irq_cond[0] = lcd_en && (mode_w == MODE_VBLANK) && (ly_w >= VBL_FIRST);
        irq_cond[1] = (src_en[3] && match_w)
                   || (src_en[2] && mode_w == MODE_OAM)
                   || (src_en[1] && mode_w == MODE_VBLANK)
                   || (src_en[0] && mode_w == MODE_HBLANK);
    end

    lcd_irq_edge #(.N(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .cond(irq_cond), .pulse(irq_pulse)
    );

    assign mode       = mode_w;
    assign ly         = ly_w;
    assign irq_vblank = irq_pulse[0];
    assign irq_stat   = irq_pulse[1];

endmodule

// File: rtl/lcd_timing_seq_chk.sv
// Assertion checker for lcd_timing_seq, attached with bind below.
module lcd_timing_seq_chk #(
    parameter int LY_W   = 8,
    parameter int LY_MAX = 152
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lcd_en,
    input logic            tick,
    input logic [1:0]      mode,
    input logic [LY_W-1:0] ly,
    input logic [7:0]      stat_rdata,
    input logic            irq_vblank,
    input logic            irq_stat
);

    a_r1_still_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_en && !tick) |=> ($stable(mode) && $stable(ly)));

    a_r2_parked_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_en |=> (mode == 2'd1 && ly == '0));

    a_r4_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ly <= LY_W'(LY_MAX));

    a_r6_mode_mirrored: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[1:0] == mode);

    a_r7_match_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(stat_rdata[2]));

    a_r9_vblank_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |=> !irq_vblank);

    a_r9_stat_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat |=> !irq_stat);

endmodule

bind lcd_timing_seq lcd_timing_seq_chk #(
    .LY_W(LY_W), .LY_MAX(VBLANK_START + VBLANK_LINES - 1)
) u_chk (.*);

// File: tb/lcd_timing_seq_test.sv
module lcd_timing_seq_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lcd_en = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] mode;
    logic [7:0] ly;
    logic [7:0] stat_rdata;
    logic       irq_vblank, irq_stat;

    int total = 0, bad = 0;
    int vcnt = 0, scnt = 0, vbase = 0, sbase = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lcd_timing_seq #(
        .DOTS_PER_TICK(4), .OAM_DOTS(8), .XFER_DOTS(12), .LINE_DOTS(28),
        .VBLANK_START(3), .VBLANK_LINES(2), .LY_W(8)
    ) uut (.*);

    // Pulse counters, sampled away from the active edge.
    always @(negedge clk) begin
        if (irq_vblank) vcnt++;
        if (irq_stat)   scnt++;
    end

    // Rows: {ticks to apply, expected mode, expected line} from enable.
    localparam logic [15:0] VEC [14] = '{
        {8'd6, 2'd1, 6'd0}, {8'd1, 2'd2, 6'd0}, {8'd1, 2'd2, 6'd0},
        {8'd1, 2'd3, 6'd0}, {8'd2, 2'd3, 6'd0}, {8'd1, 2'd0, 6'd0},
        {8'd1, 2'd0, 6'd0}, {8'd1, 2'd2, 6'd1}, {8'd7, 2'd2, 6'd2},
        {8'd6, 2'd0, 6'd2}, {8'd1, 2'd1, 6'd3}, {8'd7, 2'd1, 6'd4},
        {8'd7, 2'd2, 6'd0}, {8'd2, 2'd3, 6'd0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic snap();
        idle(3);
        vbase = vcnt; sbase = scnt;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        chk(mode == 2'd1, "R10 mode", mode, 1);
        chk(ly == 8'd0, "R10 ly", ly, 0);
        chk(stat_rdata == 8'h01, "R10 stat", stat_rdata, 8'h01);
        chk(!irq_vblank && !irq_stat, "R10 irq", {irq_vblank, irq_stat}, 0);

        // R6 software bits only
        wr(1'b0, 8'hFF);
        chk(stat_rdata == 8'hF9, "R6 write ff", stat_rdata, 8'hF9);
        wr(1'b0, 8'h07);
        chk(stat_rdata == 8'h01, "R6 low bits read-only", stat_rdata, 8'h01);

        // R2 R7 tick while disabled: still parked, match flag refreshed
        run(1);
        chk(mode == 2'd1 && ly == 8'd0, "R2 parked", {mode, ly}, 12'h100);
        chk(stat_rdata == 8'h05, "R7 match after tick", stat_rdata, 8'h05);

        // Enable and walk the vector table (R1 R3 R4)
        lcd_en = 1'b1;
        snap();
        foreach (VEC[k]) begin
            run(int'(VEC[k][15:8]));
            chk(mode == VEC[k][7:6], "R1 R3 R4 mode", mode, VEC[k][7:6]);
            chk(ly == {2'b00, VEC[k][5:0]}, "R1 R3 R4 ly", ly, VEC[k][5:0]);
            chk(stat_rdata[1:0] == mode, "R6 mode bits", stat_rdata[1:0], mode);
        end
        idle(3);
        chk(vcnt - vbase == 1, "R5 one vblank pulse, none at enable", vcnt - vbase, 1);
        chk(scnt - sbase == 0, "R8 no sources enabled", scnt - sbase, 0);

        // R8 horizontal-blank source: one per visible line
        wr(1'b0, 8'h08);
        snap();
        run(35); idle(3);
        chk(scnt - sbase == 3, "R8 hblank source", scnt - sbase, 3);
        chk(vcnt - vbase == 1, "R5 per frame", vcnt - vbase, 1);
        chk(mode == 2'd3 && ly == 8'd0, "R1 frame period", {mode, ly}, 12'h300);

        // R8 vertical-blank source
        wr(1'b0, 8'h10);
        snap();
        run(35); idle(3);
        chk(scnt - sbase == 1, "R8 vblank source", scnt - sbase, 1);

        // R8 sprite-search source: lines 1, 2 and wrapped 0
        wr(1'b0, 8'h20);
        snap();
        run(35); idle(3);
        chk(scnt - sbase == 3, "R8 search source", scnt - sbase, 3);

        // R7 R8 line-match source with compare 1
        wr(1'b0, 8'h00);
        wr(1'b1, 8'd1);
        run(1);
        chk(stat_rdata[2] == 1'b0, "R7 no match", stat_rdata[2], 0);
        wr(1'b0, 8'h40);
        snap();
        run(35); idle(3);
        chk(scnt - sbase == 1, "R8 match source", scnt - sbase, 1);
        run(4);
        chk(ly == 8'd1 && mode == 2'd2, "R3 next line", {mode, ly}, 12'h201);
        chk(stat_rdata[2] == 1'b1, "R7 match at line 1", stat_rdata[2], 1);
        wr(1'b1, 8'd2);
        chk(stat_rdata[2] == 1'b1, "R7 compare waits for tick", stat_rdata[2], 1);
        run(1);
        chk(stat_rdata[2] == 1'b0, "R7 compare applied", stat_rdata[2], 0);

        // R2 disable mid-line, ticks ignored; R4 R5 first line after enable
        lcd_en = 1'b0;
        idle(1);
        chk(mode == 2'd1 && ly == 8'd0, "R2 disable", {mode, ly}, 12'h100);
        run(3);
        chk(mode == 2'd1 && ly == 8'd0, "R2 ticks ignored", {mode, ly}, 12'h100);
        snap();
        lcd_en = 1'b1;
        run(7); idle(3);
        chk(mode == 2'd2 && ly == 8'd0, "R4 exit first blank line", {mode, ly}, 12'h200);
        chk(vcnt - vbase == 0, "R5 no pulse on enable", vcnt - vbase, 0);

        // R8 R9 overlapping sources give one edge per line
        wr(1'b0, 8'h28);
        snap();
        run(7); idle(3);
        chk(scnt - sbase == 1, "R9 combined edge", scnt - sbase, 1);
        chk(mode == 2'd2 && ly == 8'd1, "R3 line 1", {mode, ly}, 12'h201);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule